// File: doc/BRIEF.md
# Operand Bypass and Hazard Interlock Controller

This controller manages data hazards in a five-stage in-order integer pipeline. The stages run in this order: fetch, decode with register read, execute, memory access, and write-back. The controller takes the register numbers of the instruction that is about to execute. It compares them with the destinations of the two older instructions, one held in the execute/memory pipeline register and one held in the memory/write-back pipeline register. For each of the two ALU operands it selects one of three sources: the register file, the younger in-flight result, or the older in-flight result. With this selection, back-to-back ALU dependences need no stall.

A loaded value becomes available too late to be bypassed to the instruction right behind the load. When that happens, the controller freezes the program counter and the fetch/decode register for one cycle and places a no-op into the decode/execute register. The load itself keeps moving.

When the instruction in the memory stage reports a fault, the controller flushes every younger instruction in the same cycle. On the next cycle, when the faulting instruction reaches write-back, it blocks that instruction's register-file write and also stops its value from being bypassed. The register file, ALU, memories and decoder sit outside the controller and supply decoded fields and valid flags.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Each operand select output uses the code 0 for the register-file value, 1 for the execute/memory result and 2 for the memory/write-back result. The code 3 never appears, and the two operands are decided independently.
- R2: An operand takes code 1 when its source number equals the execute/memory destination and that producer has both its valid flag and its write-enable set.
- R3: An operand takes code 2 when only the memory/write-back producer matches it, with that producer's valid flag and write-enable set.
- R4: When both producers match the same source, code 1 (the younger producer) wins.
- R5: Source register 0 always takes code 0, even when a live producer names register 0.
- R6: A producer whose valid flag or write-enable is clear is never bypassed.
- R7: When the execute-stage instruction is a live load, its destination is not 0, and it equals a source that the decode-stage instruction actually uses, then `hold_front` and `idex_bubble` are both 1 in that cycle. A non-load producer, or a source that is not used, causes no hold.
- R8: After the bubble, the load sits in the memory stage with a bubble in execute, and no further hold occurs. One cycle later the consumer reaches execute and takes the loaded value with code 2, so the hold lasts exactly one cycle.
- R9: A fault on a valid memory-stage instruction raises `flush_ifid`, `idex_bubble` and `exmem_bubble` in the same cycle and forces `hold_front` to 0, even when a load-use condition is also present. A fault flag on an invalid instruction has no effect.
- R10: In the cycle after such a fault, `rf_we` is 0 even if the write-back instruction is valid and writing. In any other cycle, `rf_we` equals the write-back valid flag AND the write-back write-enable.
- R11: In the cycle after a fault, no operand takes code 2.
- R12: After reset, no cancellation is pending, so a valid writing write-back instruction drives `rf_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | AW | First source register of the decode-stage instruction |
| id_rs2 | input | AW | Second source register of the decode-stage instruction |
| id_use1 | input | 1 | Decode-stage instruction reads its first source |
| id_use2 | input | 1 | Decode-stage instruction reads its second source |
| ex_rs1 | input | AW | First source register of the execute-stage instruction |
| ex_rs2 | input | AW | Second source register of the execute-stage instruction |
| ex_rd | input | AW | Destination register of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_valid | input | 1 | Execute-stage instruction is valid |
| mem_rd | input | AW | Destination held in the execute/memory register |
| mem_we | input | 1 | Write-enable held in the execute/memory register |
| mem_valid | input | 1 | Valid flag held in the execute/memory register |
| mem_fault | input | 1 | Memory-stage instruction has faulted |
| wb_rd | input | AW | Destination held in the memory/write-back register |
| wb_we | input | 1 | Write-enable held in the memory/write-back register |
| wb_valid | input | 1 | Valid flag held in the memory/write-back register |
| sel_a | output | 2 | Source select for ALU operand A |
| sel_b | output | 2 | Source select for ALU operand B |
| hold_front | output | 1 | Freeze the program counter and the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| flush_ifid | output | 1 | Clear the fetch/decode register |
| exmem_bubble | output | 1 | Load a no-op into the execute/memory register |
| rf_we | output | 1 | Register-file write enable for the write-back instruction |

## Verification
The bench builds the controller with its default 5-bit register number, which covers 32 registers. This lets the tests reach both ends of the register range: register 0, which must never be bypassed, and register 31, the highest. The bench replays short stage snapshots to cover several cases: a load followed by its consumer through the stall, the bubble and the late bypass; a fault that arrives together with a load-use condition; and the single cycle in which a cancelled write must neither commit nor be bypassed.

// File: rtl/fwd_pkg.sv
// Shared types for the bypass and interlock controller.
// Assumes two ALU operands, each fed by a three-way multiplexer.
package fwd_pkg;
    typedef enum logic [1:0] {
        OPSRC_RF  = 2'd0,
        OPSRC_EXM = 2'd1,
        OPSRC_MWB = 2'd2
    } opsrc_e;
endpackage

// File: rtl/fwd_operand_sel.sv
// Picks the source of one ALU operand.
// Assumes the "live" inputs already combine each producer's valid flag
// and write-enable. The younger producer (execute/memory) wins over the
// older one, and register 0 is never bypassed.
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] rs,
    input  logic [AW-1:0] exm_rd,
    input  logic          exm_live,
    input  logic [AW-1:0] mwb_rd,
    input  logic          mwb_live,
    output opsrc_e        sel
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic src_nonzero;
    logic hit_exm;
    logic hit_mwb;

    assign src_nonzero = (rs != ZERO_REG);
    assign hit_exm     = src_nonzero && exm_live && (exm_rd == rs);
    assign hit_mwb     = src_nonzero && mwb_live && (mwb_rd == rs);

    // Priority choice: younger producer first, then older, then register file.
    always_comb begin
        if (hit_exm)      sel = OPSRC_EXM;
        else if (hit_mwb) sel = OPSRC_MWB;
        else              sel = OPSRC_RF;
    end
endmodule

// File: rtl/fwd_loaduse_det.sv
// Detects a load in execute whose result a decode-stage source needs.
// Assumes sources are given as a packed array with one "used" bit each.
module fwd_loaduse_det #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] id_rs,
    input  logic [NSRC-1:0]         id_use,
    input  logic [AW-1:0]           ld_rd,
    input  logic                    ld_live,
    output logic                    hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic [NSRC-1:0] src_hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // One comparator for each decode-stage source.
        assign src_hit[g] = id_use[g] && (id_rs[g] == ld_rd);
    end

    assign hit = ld_live && (ld_rd != ZERO_REG) && (|src_hit);
endmodule

// File: rtl/fwd_fault_ctl.sv
// Turns a memory-stage fault into flush requests and cancels the faulting
// instruction's write one cycle later, when it reaches write-back.
// Assumes the faulting instruction advances into write-back on the next clock.
module fwd_fault_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_live,
    input  logic wb_live_raw,
    output logic flush,
    output logic cancel_q,
    output logic rf_we
);
    // Remember that the instruction entering write-back has faulted.
    always_ff @(posedge clk) begin
        if (!rst_n) cancel_q <= 1'b0;
        else        cancel_q <= fault_live;
    end

    assign flush = fault_live;
    assign rf_we = wb_live_raw && !cancel_q;
endmodule

// File: rtl/fwd_hazard_unit.sv
// Top of the bypass and interlock controller for a five-stage in-order pipeline.
// Assumes decoded register numbers and valid flags come from the pipeline
// registers, and that the outputs drive the muxes and stage enables directly.
// A flush takes precedence over a load-use hold.
module fwd_hazard_unit
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_use1,
    input  logic          id_use2,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_load,
    input  logic          ex_valid,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          mem_valid,
    input  logic          mem_fault,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    input  logic          wb_valid,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic          hold_front,
    output logic          idex_bubble,
    output logic          flush_ifid,
    output logic          exmem_bubble,
    output logic          rf_we
);
    localparam int NSRC = 2;

    logic exm_live;
    logic mwb_live;
    logic ld_live;
    logic ld_hit;
    logic flush;
    logic cancel_q;
    opsrc_e sel_a_e;
    opsrc_e sel_b_e;
    logic [NSRC-1:0][AW-1:0] id_rs_arr;
    logic [NSRC-1:0]         id_use_arr;

    // A cancelled write-back instruction is not a legal bypass source.
    assign exm_live   = mem_valid && mem_we;
    assign mwb_live   = wb_valid && wb_we && !cancel_q;
    assign ld_live    = ex_valid && ex_we && ex_load;
    assign id_rs_arr  = {id_rs2, id_rs1};
    assign id_use_arr = {id_use2, id_use1};

    fwd_operand_sel #(.AW(AW)) u_sel_a (
        .rs(ex_rs1), .exm_rd(mem_rd), .exm_live(exm_live),
        .mwb_rd(wb_rd), .mwb_live(mwb_live), .sel(sel_a_e)
    );

    fwd_operand_sel #(.AW(AW)) u_sel_b (
        .rs(ex_rs2), .exm_rd(mem_rd), .exm_live(exm_live),
        .mwb_rd(wb_rd), .mwb_live(mwb_live), .sel(sel_b_e)
    );

    fwd_loaduse_det #(.AW(AW), .NSRC(NSRC)) u_ld (
        .id_rs(id_rs_arr), .id_use(id_use_arr),
        .ld_rd(ex_rd), .ld_live(ld_live), .hit(ld_hit)
    );

    fwd_fault_ctl u_fault (
        .clk(clk), .rst_n(rst_n),
        .fault_live(mem_valid && mem_fault),
        .wb_live_raw(wb_valid && wb_we),
        .flush(flush), .cancel_q(cancel_q), .rf_we(rf_we)
    );

    // Stage-control outputs; a flush wins over a load-use hold.
    always_comb begin
        sel_a        = sel_a_e;
        sel_b        = sel_b_e;
        hold_front   = ld_hit && !flush;
        idex_bubble  = ld_hit || flush;
        flush_ifid   = flush;
        exmem_bubble = flush;
    end
endmodule

// File: rtl/fwd_hazard_chk.sv
// Property checker for fwd_hazard_unit, attached through bind.
// Assumes only the top-level ports are visible.
module fwd_hazard_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ex_rs1,
    input logic [AW-1:0] ex_rs2,
    input logic [AW-1:0] mem_rd,
    input logic          mem_we,
    input logic          mem_valid,
    input logic          mem_fault,
    input logic [AW-1:0] wb_rd,
    input logic          wb_we,
    input logic          wb_valid,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic          hold_front,
    input logic          idex_bubble,
    input logic          flush_ifid,
    input logic          exmem_bubble,
    input logic          rf_we
);
    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'd3) && (sel_b != 2'd3));

    a_r4_younger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 != '0 && mem_valid && mem_we && mem_rd == ex_rs1 &&
         wb_valid && wb_we && wb_rd == ex_rs1) |-> sel_a == 2'd1);

    a_r5_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> sel_a == 2'd0);

    a_r6_dead_producers: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid && !wb_valid) |-> (sel_a == 2'd0 && sel_b == 2'd0));

    a_r7_hold_has_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        hold_front |-> idex_bubble);

    a_r9_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_fault) |-> (flush_ifid && exmem_bubble && idex_bubble && !hold_front));

    a_r10_cancel_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mem_valid && mem_fault)) |-> !rf_we);

    a_r11_no_cancelled_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mem_valid && mem_fault)) |-> (sel_a != 2'd2 && sel_b != 2'd2));
endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_valid(mem_valid), .mem_fault(mem_fault),
    .wb_rd(wb_rd), .wb_we(wb_we), .wb_valid(wb_valid),
    .sel_a(sel_a), .sel_b(sel_b), .hold_front(hold_front), .idex_bubble(idex_bubble),
    .flush_ifid(flush_ifid), .exmem_bubble(exmem_bubble), .rf_we(rf_we)
);

// File: tb/fwd_hazard_unit_test.sv
`timescale 1ns/1ps
// Directed bench for fwd_hazard_unit: one task per scenario.
module fwd_hazard_unit_test;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_use1, id_use2, ex_we, ex_load, ex_valid;
    logic mem_we, mem_valid, mem_fault, wb_we, wb_valid;
    logic [1:0] sel_a, sel_b;
    logic hold_front, idex_bubble, flush_ifid, exmem_bubble, rf_we;
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    fwd_hazard_unit #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use1(id_use1), .id_use2(id_use2),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
        .ex_load(ex_load), .ex_valid(ex_valid),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_valid(mem_valid), .mem_fault(mem_fault),
        .wb_rd(wb_rd), .wb_we(wb_we), .wb_valid(wb_valid),
        .sel_a(sel_a), .sel_b(sel_b), .hold_front(hold_front), .idex_bubble(idex_bubble),
        .flush_ifid(flush_ifid), .exmem_bubble(exmem_bubble), .rf_we(rf_we)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
        {id_use1, id_use2, ex_we, ex_load, ex_valid} = '0;
        {mem_we, mem_valid, mem_fault, wb_we, wb_valid} = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle();
        wb_rd = 5'd8; wb_we = 1'b1; wb_valid = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12 rf_we after reset", rf_we, 1);
        chk("R1 sel_a idle", sel_a, 0);
        chk("R10 no fault hold", hold_front, 0);
        idle();
    endtask

    task automatic t_bypass();
        @(negedge clk); idle();
        ex_rs1 = 5'd5; ex_rs2 = 5'd6;
        mem_rd = 5'd5; mem_we = 1'b1; mem_valid = 1'b1;
        #1;
        chk("R2 exm match sel_a", sel_a, 1);
        chk("R1 other operand independent", sel_b, 0);
        @(negedge clk); idle();
        ex_rs1 = 5'd1; ex_rs2 = 5'd7;
        wb_rd = 5'd7; wb_we = 1'b1; wb_valid = 1'b1;
        #1;
        chk("R3 mwb match sel_b", sel_b, 2);
        chk("R3 sel_a unmatched", sel_a, 0);
        @(negedge clk); idle();
        ex_rs1 = 5'd31; ex_rs2 = 5'd31;
        mem_rd = 5'd31; mem_we = 1'b1; mem_valid = 1'b1;
        wb_rd = 5'd31; wb_we = 1'b1; wb_valid = 1'b1;
        #1;
        chk("R4 priority sel_a", sel_a, 1);
        chk("R4 priority sel_b", sel_b, 1);
    endtask

    task automatic t_gating();
        @(negedge clk); idle();
        ex_rs1 = 5'd0; ex_rs2 = 5'd0;
        mem_rd = 5'd0; mem_we = 1'b1; mem_valid = 1'b1;
        wb_rd = 5'd0; wb_we = 1'b1; wb_valid = 1'b1;
        #1;
        chk("R5 zero reg sel_a", sel_a, 0);
        chk("R5 zero reg sel_b", sel_b, 0);
        @(negedge clk); idle();
        ex_rs1 = 5'd9; ex_rs2 = 5'd10;
        mem_rd = 5'd9; mem_we = 1'b0; mem_valid = 1'b1;
        wb_rd = 5'd10; wb_we = 1'b1; wb_valid = 1'b0;
        #1;
        chk("R6 no write-enable", sel_a, 0);
        chk("R6 not valid", sel_b, 0);
    endtask

    task automatic t_loaduse();
        @(negedge clk); idle();
        ex_rd = 5'd3; ex_we = 1'b1; ex_load = 1'b1; ex_valid = 1'b1;
        id_rs1 = 5'd4; id_rs2 = 5'd3; id_use1 = 1'b1; id_use2 = 1'b1;
        #1;
        chk("R7 load-use hold", hold_front, 1);
        chk("R7 load-use bubble", idex_bubble, 1);
        chk("R7 no flush on stall", flush_ifid, 0);
        id_use2 = 1'b0; #1;
        chk("R7 unused source", hold_front, 0);
        id_use2 = 1'b1; ex_load = 1'b0; #1;
        chk("R7 alu producer no stall", hold_front, 0);
        ex_load = 1'b1; ex_rd = 5'd0; id_rs2 = 5'd0; #1;
        chk("R7 load to r0 no stall", hold_front, 0);
        // Cycle after the hold: load in memory stage, bubble in execute.
        @(negedge clk); idle();
        mem_rd = 5'd3; mem_we = 1'b1; mem_valid = 1'b1;
        id_rs1 = 5'd4; id_rs2 = 5'd3; id_use1 = 1'b1; id_use2 = 1'b1;
        #1;
        chk("R8 single cycle hold", hold_front, 0);
        chk("R8 no second bubble", idex_bubble, 0);
        // Next cycle: load in write-back, consumer in execute.
        @(negedge clk); idle();
        wb_rd = 5'd3; wb_we = 1'b1; wb_valid = 1'b1;
        ex_rs1 = 5'd4; ex_rs2 = 5'd3;
        #1;
        chk("R8 consumer takes loaded value", sel_b, 2);
    endtask

    task automatic t_fault();
        @(negedge clk); idle();
        mem_valid = 1'b1; mem_fault = 1'b1; mem_we = 1'b1; mem_rd = 5'd4;
        ex_rd = 5'd2; ex_we = 1'b1; ex_load = 1'b1; ex_valid = 1'b1;
        id_rs1 = 5'd2; id_use1 = 1'b1;
        #1;
        chk("R9 flush_ifid", flush_ifid, 1);
        chk("R9 idex_bubble", idex_bubble, 1);
        chk("R9 exmem_bubble", exmem_bubble, 1);
        chk("R9 flush overrides hold", hold_front, 0);
        @(negedge clk); idle();
        wb_rd = 5'd4; wb_we = 1'b1; wb_valid = 1'b1;
        ex_rs1 = 5'd4;
        #1;
        chk("R10 cancelled write", rf_we, 0);
        chk("R11 cancelled not bypassed", sel_a, 0);
        @(negedge clk);
        #1;
        chk("R10 write resumes", rf_we, 1);
        chk("R11 bypass resumes", sel_a, 2);
        @(negedge clk); idle();
        mem_fault = 1'b1; mem_valid = 1'b0;
        #1;
        chk("R9 invalid fault ignored", flush_ifid, 0);
        @(negedge clk); idle();
        wb_we = 1'b1; wb_valid = 1'b1; wb_rd = 5'd6;
        #1;
        chk("R9 invalid fault no cancel", rf_we, 1);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_bypass();
        t_gating();
        t_loaduse();
        t_fault();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule